// File: doc/BRIEF.md
# Power-Fail Write-Protect Sequencer

This block sits between a host's memory controls and a battery-backed static memory and decides, from two supply-monitor flags, when the memory may be touched. One flag says the supply has dropped below the deselect threshold. The other says it has dropped below the lower battery-switchover threshold. A third input tells the block that a memory access is currently in flight. Both supply flags are assumed to be synchronous to `clk_i` already.

On a supply fault the block lets an access that has already started run to its end, but only inside a bounded grace window. After that it protects the memory. While protected it forces the data bus to high impedance and blocks every control strobe. Below the switchover level it selects the battery. When the supply comes back, it keeps protection for a long recovery interval before access is allowed again. Grace and recovery lengths are parameters counted in clock cycles.

Reset lands in the protected state, so a complete recovery interval with good supply must pass before the first access.

Top module: `pfs_seq`

## Requirements
- R1: While `rst_ni` is low and just after it rises, `state_o` is 2 (protected), `protect_o` and `hiz_o` are 1, and `batt_sel_o` is 0.
- R2: In normal state (0), a sampled `supply_low_i` with `access_busy_i` low moves the block to protected (2) at that clock edge, so `protect_o` is 1 one cycle later.
- R3: In normal state, a sampled `supply_low_i` with `access_busy_i` high moves the block to grace (1). In grace, `protect_o` stays 0 and controls pass through. The block goes to protected at the first edge where `access_busy_i` is sampled low.
- R4: Grace lasts at most `GRACE_CYC` cycles. If the access is still busy after that, the block is forced to protected.
- R5: While `protect_o` is 1, `hiz_o` is 1 and `mem_en_o`, `mem_wr_o` and `mem_rd_o` are 0 whatever the request inputs are.
- R6: In protected state, a sampled `supply_dead_i` moves the block to battery (3) with `batt_sel_o`=1. In battery state, a sampled low `supply_dead_i` returns it to protected with `batt_sel_o`=0.
- R7: Battery state is entered only from protected. `supply_dead_i` seen in normal, grace or recovery never sets `batt_sel_o` directly.
- R8: In protected state, a sampled low `supply_low_i` (with `supply_dead_i` low) enters recovery (4). The block returns to normal after exactly `RECOV_CYC` cycles in recovery, with protection held throughout.
- R9: A sampled `supply_low_i` during recovery returns the block to protected. Re-entry into recovery starts a full new interval.
- R10: `state_o` encodes normal=0, grace=1, protected=2, battery=3, recovery=4.
- R11: In normal and grace, `mem_en_o`, `mem_wr_o` and `mem_rd_o` follow `req_en_i`, `req_wr_i` and `req_rd_i` in the same cycle, `hiz_o` is 0 and `batt_sel_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| supply_low_i | input | 1 | Supply below deselect threshold |
| supply_dead_i | input | 1 | Supply below battery switchover threshold |
| access_busy_i | input | 1 | A memory access is in flight |
| req_en_i | input | 1 | Host memory enable request |
| req_wr_i | input | 1 | Host write strobe request |
| req_rd_i | input | 1 | Host output-enable request |
| mem_en_o | output | 1 | Gated memory enable |
| mem_wr_o | output | 1 | Gated write strobe |
| mem_rd_o | output | 1 | Gated output enable |
| protect_o | output | 1 | Write-protect / deselect active |
| hiz_o | output | 1 | Force data bus to high impedance |
| batt_sel_o | output | 1 | Select battery supply |
| state_o | output | 3 | Current state encoding |

## Verification
All state-derived outputs (`state_o`, `protect_o`, `hiz_o`, `batt_sel_o`) are decoded from one state register. They change one clock edge after the supply or busy input is sampled. The gated memory strobes combine that register with the request inputs and respond in the same cycle. The bench drives inputs on the falling edge. It advances a behavioural model on each rising edge and compares every output 2 ns after that edge, so both kinds of result are sampled where they are due. Grace and recovery are timed by counting cycles spent in the model state, which places the forced-protect edge at exactly `GRACE_CYC` cycles and the return to normal at exactly `RECOV_CYC` cycles after entry.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  typedef enum logic [2:0] {
    ST_NORMAL = 3'd0,
    ST_GRACE  = 3'd1,
    ST_PROT   = 3'd2,
    ST_BATT   = 3'd3,
    ST_RECOV  = 3'd4
  } pfs_state_e;

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/pfs_tick_timer.sv
module pfs_tick_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          en_i,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (clr_i)               cnt_q <= '0;
    else if (en_i && cnt_q != '1) cnt_q <= cnt_q + 1'b1;  // saturate
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pfs_state_ctl.sv
module pfs_state_ctl
  import pfs_pkg::*;
#(
  parameter int unsigned GRACE_CYC = 8,
  parameter int unsigned RECOV_CYC = 64,
  parameter int unsigned CW        = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          supply_low_i,
  input  logic          supply_dead_i,
  input  logic          access_busy_i,
  input  logic [CW-1:0] cnt_i,
  output pfs_state_e    state_o,
  output logic          tmr_clr_o,
  output logic          tmr_en_o
);
  localparam logic [CW-1:0] GraceLast = CW'(GRACE_CYC - 1);
  localparam logic [CW-1:0] RecovLast = CW'(RECOV_CYC - 1);

  pfs_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_NORMAL: if (supply_low_i) state_d = access_busy_i ? ST_GRACE : ST_PROT;
      ST_GRACE:  if (!access_busy_i || cnt_i == GraceLast) state_d = ST_PROT;
      ST_PROT: begin
        if (supply_dead_i)      state_d = ST_BATT;
        else if (!supply_low_i) state_d = ST_RECOV;
      end
      ST_BATT:   if (!supply_dead_i) state_d = ST_PROT;
      ST_RECOV: begin
        if (supply_low_i)            state_d = ST_PROT;
        else if (cnt_i == RecovLast) state_d = ST_NORMAL;
      end
      default:   state_d = ST_PROT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_PROT;
    else         state_q <= state_d;
  end

  assign state_o   = state_q;
  assign tmr_clr_o = (state_d != state_q);
  assign tmr_en_o  = (state_q == ST_GRACE) || (state_q == ST_RECOV);
endmodule

// File: rtl/pfs_access_gate.sv
module pfs_access_gate
  import pfs_pkg::*;
#(
  parameter int unsigned N_CTL = 3
) (
  input  pfs_state_e       state_i,
  input  logic [N_CTL-1:0] req_i,
  output logic [N_CTL-1:0] mem_o,
  output logic             protect_o,
  output logic             hiz_o,
  output logic             batt_sel_o
);
  logic open_q;

  assign open_q     = (state_i == ST_NORMAL) || (state_i == ST_GRACE);
  assign protect_o  = !open_q;
  assign hiz_o      = !open_q;
  assign batt_sel_o = (state_i == ST_BATT);

  for (genvar g = 0; g < N_CTL; g++) begin : g_gate
    assign mem_o[g] = req_i[g] & open_q;
  end
endmodule

// File: rtl/pfs_seq.sv
module pfs_seq
  import pfs_pkg::*;
#(
  parameter int unsigned GRACE_CYC = 8000,
  parameter int unsigned RECOV_CYC = 8000000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       supply_low_i,
  input  logic       supply_dead_i,
  input  logic       access_busy_i,
  input  logic       req_en_i,
  input  logic       req_wr_i,
  input  logic       req_rd_i,
  output logic       mem_en_o,
  output logic       mem_wr_o,
  output logic       mem_rd_o,
  output logic       protect_o,
  output logic       hiz_o,
  output logic       batt_sel_o,
  output logic [2:0] state_o
);
  localparam int unsigned NCtl = 3;
  localparam int unsigned CW   = $clog2(max_u(GRACE_CYC, RECOV_CYC) + 1);

  pfs_state_e      state;
  logic            tmr_clr, tmr_en;
  logic [CW-1:0]   cnt;
  logic [NCtl-1:0] req, mem;

  pfs_tick_timer #(.CW(CW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (tmr_clr),
    .en_i   (tmr_en),
    .cnt_o  (cnt)
  );

  pfs_state_ctl #(.GRACE_CYC(GRACE_CYC), .RECOV_CYC(RECOV_CYC), .CW(CW)) u_ctl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .supply_low_i  (supply_low_i),
    .supply_dead_i (supply_dead_i),
    .access_busy_i (access_busy_i),
    .cnt_i         (cnt),
    .state_o       (state),
    .tmr_clr_o     (tmr_clr),
    .tmr_en_o      (tmr_en)
  );

  assign req = {req_rd_i, req_wr_i, req_en_i};

  pfs_access_gate #(.N_CTL(NCtl)) u_gate (
    .state_i    (state),
    .req_i      (req),
    .mem_o      (mem),
    .protect_o  (protect_o),
    .hiz_o      (hiz_o),
    .batt_sel_o (batt_sel_o)
  );

  assign mem_en_o = mem[0];
  assign mem_wr_o = mem[1];
  assign mem_rd_o = mem[2];
  assign state_o  = state;
endmodule

// File: rtl/pfs_seq_chk.sv
module pfs_seq_chk #(
  parameter int unsigned GRACE_CYC = 8000,
  parameter int unsigned RECOV_CYC = 8000000
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       supply_low_i,
  input logic       supply_dead_i,
  input logic       access_busy_i,
  input logic       req_en_i,
  input logic       req_wr_i,
  input logic       req_rd_i,
  input logic       mem_en_o,
  input logic       mem_wr_o,
  input logic       mem_rd_o,
  input logic       protect_o,
  input logic       hiz_o,
  input logic       batt_sel_o,
  input logic [2:0] state_o
);
  int unsigned grace_n, recov_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grace_n <= 0;
      recov_n <= 0;
    end else begin
      grace_n <= (state_o == 3'd1) ? grace_n + 1 : 0;
      recov_n <= (state_o == 3'd4) ? recov_n + 1 : 0;
    end
  end

  a_r2_fail_idle_protects: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd0 && supply_low_i && !access_busy_i) |=> protect_o);

  a_r3_fail_busy_grace: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd0 && supply_low_i && access_busy_i) |=> (state_o == 3'd1 && !protect_o));

  a_r4_grace_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd1) |-> (grace_n < GRACE_CYC));

  a_r5_protect_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    protect_o |-> (hiz_o && !mem_en_o && !mem_wr_o && !mem_rd_o));

  a_r6_batt_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (batt_sel_o && !supply_dead_i) |=> !batt_sel_o);

  a_r7_batt_from_prot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(batt_sel_o) |-> ($past(state_o) == 3'd2));

  a_r8_recov_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd4) |-> (recov_n < RECOV_CYC && protect_o));

  a_r9_dip_reprotects: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd4 && supply_low_i) |=> (state_o == 3'd2));

  a_r11_open_passes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !protect_o |-> (mem_en_o == req_en_i && mem_wr_o == req_wr_i && mem_rd_o == req_rd_i));
endmodule

bind pfs_seq pfs_seq_chk #(.GRACE_CYC(GRACE_CYC), .RECOV_CYC(RECOV_CYC)) u_chk (.*);

// File: tb/pfs_seq_tb_top.sv
module pfs_seq_tb_top;
  localparam int G = 6;
  localparam int R = 20;
  localparam int S_NORMAL = 0, S_GRACE = 1, S_PROT = 2, S_BATT = 3, S_RECOV = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic low = 1'b0, dead = 1'b0, busy = 1'b0;
  logic r_en = 1'b0, r_wr = 1'b0, r_rd = 1'b0;
  logic m_en, m_wr, m_rd, prot, hiz, batt;
  logic [2:0] st;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int m_st = S_PROT, tick = 0;
  bit chk_on = 1'b0, done = 1'b0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  pfs_seq #(.GRACE_CYC(G), .RECOV_CYC(R)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .supply_low_i(low), .supply_dead_i(dead),
    .access_busy_i(busy), .req_en_i(r_en), .req_wr_i(r_wr), .req_rd_i(r_rd),
    .mem_en_o(m_en), .mem_wr_o(m_wr), .mem_rd_o(m_rd), .protect_o(prot),
    .hiz_o(hiz), .batt_sel_o(batt), .state_o(st));

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    int nxt, spent;
    cyc++;
    if (!rst_n) begin
      m_st = S_PROT; tick = 0;
    end else begin
      nxt = m_st; spent = tick + 1;
      case (m_st)
        S_NORMAL: if (low) nxt = busy ? S_GRACE : S_PROT;
        S_GRACE:  if (!busy || spent >= G) nxt = S_PROT;
        S_PROT:   if (dead) nxt = S_BATT; else if (!low) nxt = S_RECOV;
        S_BATT:   if (!dead) nxt = S_PROT;
        S_RECOV:  if (low) nxt = S_PROT; else if (spent >= R) nxt = S_NORMAL;
        default:  nxt = S_PROT;
      endcase
      tick = (nxt != m_st) ? 0 : spent;
      m_st = nxt;
    end
    #2;
    if (chk_on) begin
      bit open;
      open = (m_st == S_NORMAL) || (m_st == S_GRACE);
      check(int'(st) == m_st, cur_req, "state_o (R10)", int'(st), m_st);
      check(prot == !open, cur_req, "protect_o", int'(prot), int'(!open));
      check(hiz == !open, cur_req, "hiz_o (R5)", int'(hiz), int'(!open));
      check(batt == (m_st == S_BATT), cur_req, "batt_sel_o (R6)", int'(batt), int'(m_st == S_BATT));
      check({m_rd, m_wr, m_en} == ({r_rd, r_wr, r_en} & {3{open}}), cur_req,
            "mem strobes (R5/R11)", int'({m_rd, m_wr, m_en}), int'({r_rd, r_wr, r_en} & {3{open}}));
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_req(input logic [2:0] v);
    {r_rd, r_wr, r_en} = v;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    step(3);
    // R1: reset state
    check(int'(st) == S_PROT && prot && hiz && !batt, "R1", "reset state", int'(st), S_PROT);
    drive_req(3'b111);
    step(1);
    check(!m_en && !m_wr && !m_rd, "R5", "strobes blocked in reset", int'({m_rd, m_wr, m_en}), 0);
    rst_n = 1'b1;
    #1 check(int'(st) == S_PROT && prot, "R1", "state after reset release", int'(st), S_PROT);
    chk_on = 1'b1;

    // R8: full recovery to normal
    cur_req = "R8";
    step(R - 1);
    check(prot, "R8", "still protected before recovery end", int'(prot), 1);
    step(3);
    check(int'(st) == S_NORMAL && !prot, "R8", "normal after recovery", int'(st), S_NORMAL);

    // R11: pass-through patterns
    cur_req = "R11";
    for (int v = 0; v < 8; v++) begin drive_req(3'(v)); step(1); end

    // R2: fail with no access in flight
    cur_req = "R2";
    low = 1'b1; busy = 1'b0; drive_req(3'b011);
    step(1);
    check(prot && int'(st) == S_PROT, "R2", "protected one edge after fail", int'(st), S_PROT);

    // R5: requests ignored while protected
    cur_req = "R5";
    for (int v = 0; v < 8; v++) begin
      drive_req(3'(v)); step(1);
      check({m_rd, m_wr, m_en} == 3'b000 && hiz, "R5", "strobes while protected", int'({m_rd, m_wr, m_en}), 0);
    end

    // R6: battery entry and release
    cur_req = "R6";
    dead = 1'b1; step(2);
    check(batt && int'(st) == S_BATT, "R6", "battery selected", int'(batt), 1);
    dead = 1'b0; step(1);
    check(!batt && int'(st) == S_PROT, "R6", "battery released", int'(batt), 0);

    // R9: dip during recovery restarts interval
    cur_req = "R9";
    low = 1'b0; step(R / 2);
    low = 1'b1; step(1);
    check(int'(st) == S_PROT, "R9", "dip returns to protected", int'(st), S_PROT);
    low = 1'b0; step(R - 2);
    check(int'(st) == S_RECOV && prot, "R9", "recovery restarted in full", int'(st), S_RECOV);
    step(4);
    check(int'(st) == S_NORMAL, "R9", "normal after restarted recovery", int'(st), S_NORMAL);

    // R3: access in flight finishes inside grace
    cur_req = "R3";
    drive_req(3'b101); busy = 1'b1; low = 1'b1; step(1);
    check(int'(st) == S_GRACE && !prot && m_en && m_rd, "R3", "grace keeps access open", int'(st), S_GRACE);
    step(2); busy = 1'b0; step(1);
    check(int'(st) == S_PROT, "R3", "protected when access ends", int'(st), S_PROT);
    low = 1'b0; step(R + 3);

    // R4: access overruns grace window
    cur_req = "R4";
    busy = 1'b1; low = 1'b1; step(G);
    check(int'(st) == S_GRACE, "R4", "last grace cycle", int'(st), S_GRACE);
    step(1);
    check(int'(st) == S_PROT && prot, "R4", "forced protect after grace", int'(st), S_PROT);
    busy = 1'b0; low = 1'b0; step(R + 3);

    // R7: switchover seen in normal does not select battery directly
    cur_req = "R7";
    low = 1'b1; dead = 1'b1; busy = 1'b1; step(1);
    check(!batt && int'(st) == S_GRACE, "R7", "no battery from normal", int'(batt), 0);
    busy = 1'b0; step(1);
    check(!batt && int'(st) == S_PROT, "R7", "protected before battery", int'(st), S_PROT);
    step(1);
    check(batt, "R7", "battery after protected", int'(batt), 1);
    dead = 1'b0; low = 1'b0; step(R + 4);
    check(int'(st) == S_NORMAL, "R8", "normal after final recovery", int'(st), S_NORMAL);

    done = 1'b1;
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end
endmodule